// File: doc/BRIEF.md
# Ramp and Tracking Converter Controller

This block is the digital half of an analogue-to-digital converter built from one comparator and an N-bit DAC. It drives the DAC code, reads back the comparator decision, and produces an N-bit result. It has two modes. In ramp mode, a start pulse clears the code to zero. The code then climbs by one per clock until the comparator reports that the DAC output has risen above the input. The count at that point is the result. A sample-hold line is held low for the whole conversion, so the analogue input stays frozen while the code climbs. A ready line rises when the result is valid.

In tracking mode the code is never cleared. On every clock it moves one step up or down, and the comparator decides which way. The code therefore follows a slowly moving input. It stops at zero and at full scale and never wraps.

The comparator input is asynchronous to the block, so it passes through a two-flop synchronizer. In ramp mode the controller corrects for the latency of that synchronizer. The reported result is the first code whose comparator decision was high, even though by then the ramp has run on by the synchronizer depth.

Top module: `ramp_adc_ctrl`

## Requirements
- R1: After reset, ready and sample-hold are high, the DAC code is 0, the result is 0 and the block is in ramp mode.
- R2: In ramp mode (mode_i = 0), a start pulse while idle drives ready and sample-hold low on the next clock, with the DAC code at 0.
- R3: While a conversion runs, the DAC code rises by exactly one per clock, from 0. It is clipped at full scale 2^N-1.
- R4: The comparator input is 1 when the DAC output is above the input. The result is the smallest code whose comparator decision was 1, or 2^N-1 if no code up to full scale gave a 1.
- R5: A conversion with result n keeps ready low for exactly n+3 clocks. Ready then rises, and sample-hold returns high in the same cycle.
- R6: A start pulse that arrives during a conversion has no effect. The length and the result of that conversion are unchanged.
- R7: The ramp-mode result stays unchanged from the end of one conversion until the end of the next, whatever the comparator does in between.
- R8: In tracking mode (mode_i = 1), ready and sample-hold stay high and the result equals the DAC code. The code changes on every clock: down by one if the comparator sampled three clocks earlier was 1, up by one if it was 0.
- R9: In tracking mode the code saturates at 0 and at 2^N-1 and does not wrap.
- R10: A change of mode_i ends any running conversion, so ready is high on the next clock. Start pulses have no effect while in tracking mode.
- R11: While the ramp code is below the synchronizer depth (2), the comparator is ignored. A decision left over from before the start cannot end the new conversion early.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse for a ramp conversion |
| mode_i | input | 1 | 0 = ramp mode, 1 = tracking mode |
| cmp_i | input | 1 | Comparator, 1 when the DAC output is above the input; asynchronous |
| dac_code_o | output | N | Code to the DAC |
| result_o | output | N | Conversion result (current code in tracking mode) |
| ready_o | output | 1 | High when not converting; a rising edge marks a new result |
| hold_n_o | output | 1 | Sample-hold control: high to sample, low to hold |

## Verification
The assertions assume that the comparator is a memoryless function of the current DAC code against an input that stays fixed during a conversion. The bench meets that assumption with a behavioural comparator, `code >= level`, where the integer level is changed only on a falling clock edge between conversions or between tracking windows. Levels are drawn at random across the whole range and one step above full scale. Directed cases cover zero, full scale, a leftover high decision at start, a start pulse during a conversion, and a mode change in the middle of a conversion.

// File: rtl/ramp_adc_pkg.sv
package ramp_adc_pkg;

    typedef enum logic {
        MODE_COUNT = 1'b0,
        MODE_TRACK = 1'b1
    } adc_mode_e;

    // One-cycle command to the code counter.
    typedef struct packed {
        logic clamp;   // mode change: pull the code back into range
        logic clr;     // start of a ramp
        logic ramp;    // ramp step up
        logic track;   // tracking step
        logic down;    // tracking direction
    } cnt_ctrl_t;

    // Width that holds codes 0 .. 2^n-1+s (ramp overshoot by sync depth).
    function automatic int cnt_width(input int n, input int s);
        return $clog2((2 ** n) + s);
    endfunction

endpackage

// File: rtl/adc_cmp_sync.sv
module adc_cmp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b0;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import ramp_adc_pkg::*;
#(
    parameter int N    = 6,
    parameter int SYNC = 2,
    parameter int CW   = cnt_width(N, SYNC)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    input  adc_mode_e       mode_i,
    input  logic            cmp_s_i,
    input  logic [CW-1:0]   cnt_i,
    output cnt_ctrl_t       ctrl_o,
    output logic            busy_o,
    output logic            stop_o,
    output adc_mode_e       mode_o
);
    localparam logic [CW-1:0] BLANK = CW'(SYNC);
    localparam logic [CW-1:0] LAST  = CW'((2 ** N) - 1 + SYNC);

    adc_mode_e mode_q;
    logic      busy_q;
    logic      switch_w;
    logic      start_ok;
    logic      stop_w;

    assign switch_w = (mode_i != mode_q);
    assign start_ok = start_i && !busy_q && (mode_q == MODE_COUNT) && !switch_w;
    // Decision from cnt-SYNC is what cmp_s reflects; blank the stale ones.
    assign stop_w   = busy_q && !switch_w &&
                      (((cnt_i >= BLANK) && cmp_s_i) || (cnt_i == LAST));

    always_comb begin
        ctrl_o       = '0;
        ctrl_o.clamp = switch_w;
        ctrl_o.clr   = start_ok;
        ctrl_o.ramp  = busy_q && !switch_w && !stop_w;
        ctrl_o.track = (mode_q == MODE_TRACK) && !switch_w;
        ctrl_o.down  = cmp_s_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_COUNT;
            busy_q <= 1'b0;
        end else begin
            mode_q <= mode_i;
            if (switch_w)      busy_q <= 1'b0;
            else if (start_ok) busy_q <= 1'b1;
            else if (stop_w)   busy_q <= 1'b0;
        end
    end

    assign busy_o = busy_q;
    assign stop_o = stop_w;
    assign mode_o = mode_q;

    // R10: a mode change always leaves the controller idle
    a_r10_idle_on_switch: assert property (@(posedge clk) disable iff (rst)
        switch_w |=> !busy_q);

    // R6: a running conversion only ends through a stop or a mode change
    a_r6_busy_holds: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !stop_w && !switch_w) |=> busy_q);

    // R11: no stop while the ramp is inside the blanking window
    a_r11_blank: assert property (@(posedge clk) disable iff (rst)
        (busy_q && (cnt_i < BLANK)) |-> !stop_w);

    // R2: an accepted start leaves the counter at zero and busy set
    a_r2_start_arms: assert property (@(posedge clk) disable iff (rst)
        start_ok |=> (busy_q && (cnt_i == '0)));

    // R10: no conversion in tracking mode
    a_r10_track_idle: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_TRACK) |-> !busy_q);
endmodule

// File: rtl/adc_code_cnt.sv
module adc_code_cnt
    import ramp_adc_pkg::*;
#(
    parameter int N    = 6,
    parameter int SYNC = 2,
    parameter int CW   = cnt_width(N, SYNC)
) (
    input  logic           clk,
    input  logic           rst,
    input  cnt_ctrl_t      ctrl_i,
    output logic [CW-1:0]  cnt_o,
    output logic [N-1:0]   code_o
);
    localparam logic [CW-1:0] TOP = CW'((2 ** N) - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] clip_w;

    assign clip_w = (cnt_q > TOP) ? TOP : cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (ctrl_i.clamp) begin
            cnt_q <= clip_w;
        end else if (ctrl_i.clr) begin
            cnt_q <= '0;
        end else if (ctrl_i.ramp) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (ctrl_i.track) begin
            if (ctrl_i.down) cnt_q <= (cnt_q == '0) ? '0 : cnt_q - 1'b1;
            else             cnt_q <= (cnt_q >= TOP) ? TOP : cnt_q + 1'b1;
        end
    end

    assign cnt_o  = cnt_q;
    assign code_o = clip_w[N-1:0];

    // R3: a ramp step adds exactly one
    a_r3_ramp_step: assert property (@(posedge clk) disable iff (rst)
        (ctrl_i.ramp && !ctrl_i.clamp && !ctrl_i.clr) |=>
        (int'(cnt_q) == int'($past(cnt_q)) + 1));

    // R9: tracking never leaves the code range
    a_r9_track_range: assert property (@(posedge clk) disable iff (rst)
        ctrl_i.track |-> (cnt_q <= TOP));

    // R9: no wrap at full scale or at zero
    a_r9_no_wrap_top: assert property (@(posedge clk) disable iff (rst)
        (ctrl_i.track && !ctrl_i.down && (cnt_q == TOP)) |=> (cnt_q == TOP));
    a_r9_no_wrap_zero: assert property (@(posedge clk) disable iff (rst)
        (ctrl_i.track && ctrl_i.down && (cnt_q == '0)) |=> (cnt_q == '0));

    // R8: a tracking step moves the code by at most one
    a_r8_track_step: assert property (@(posedge clk) disable iff (rst)
        ctrl_i.track |=>
        ((int'(cnt_q) - int'($past(cnt_q)) <= 1) &&
         (int'($past(cnt_q)) - int'(cnt_q) <= 1)));
endmodule

// File: rtl/ramp_adc_ctrl.sv
module ramp_adc_ctrl
    import ramp_adc_pkg::*;
#(
    parameter int N    = 6,
    parameter int SYNC = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          mode_i,
    input  logic          cmp_i,
    output logic [N-1:0]  dac_code_o,
    output logic [N-1:0]  result_o,
    output logic          ready_o,
    output logic          hold_n_o
);
    localparam int CW = cnt_width(N, SYNC);

    logic          cmp_s;
    cnt_ctrl_t     ctrl;
    logic [CW-1:0] cnt;
    logic [N-1:0]  code;
    logic          busy;
    logic          stop;
    adc_mode_e     mode_q;
    logic [N-1:0]  result_q;
    logic [CW-1:0] back_w;

    adc_cmp_sync #(.STAGES(SYNC)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (cmp_i),
        .q_o (cmp_s)
    );

    adc_seq_ctrl #(.N(N), .SYNC(SYNC), .CW(CW)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .mode_i  (adc_mode_e'(mode_i)),
        .cmp_s_i (cmp_s),
        .cnt_i   (cnt),
        .ctrl_o  (ctrl),
        .busy_o  (busy),
        .stop_o  (stop),
        .mode_o  (mode_q)
    );

    adc_code_cnt #(.N(N), .SYNC(SYNC), .CW(CW)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .ctrl_i (ctrl),
        .cnt_o  (cnt),
        .code_o (code)
    );

    // Undo the synchronizer overshoot when the ramp stops.
    assign back_w = cnt - CW'(SYNC);

    always_ff @(posedge clk) begin
        if (rst)       result_q <= '0;
        else if (stop) result_q <= back_w[N-1:0];
    end

    assign dac_code_o = code;
    assign result_o   = (mode_q == MODE_TRACK) ? code : result_q;
    assign ready_o    = !busy;
    assign hold_n_o   = !busy;

    // R7: the ramp result only changes when a conversion ends
    a_r7_result_hold: assert property (@(posedge clk) disable iff (rst)
        !stop |=> $stable(result_q));

    // R5: a conversion ends with ready rising
    a_r5_stop_ready: assert property (@(posedge clk) disable iff (rst)
        stop |=> ready_o);
endmodule

// File: tb/ramp_adc_ctrl_bench.sv
module ramp_adc_ctrl_bench;
    localparam int N    = 6;
    localparam int SYNC = 2;
    localparam int MAXC = (2 ** N) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         mode = 1'b0;
    logic         cmp;
    logic [N-1:0] dac, result;
    logic         ready, hold_n;
    int           level = 0;
    int           checks = 0;
    int           errors = 0;
    int           cyc = 0;
    int           last_res = 0;

    always #5 clk = ~clk;

    // Behavioural comparator: DAC output above the input.
    assign cmp = (int'(dac) >= level);

    ramp_adc_ctrl #(.N(N), .SYNC(SYNC)) u_ramp_adc_ctrl (
        .clk(clk), .rst(rst), .start_i(start), .mode_i(mode), .cmp_i(cmp),
        .dac_code_o(dac), .result_o(result), .ready_o(ready), .hold_n_o(hold_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_result(input int v);
        return (v > MAXC) ? MAXC : v;
    endfunction

    function automatic int step(input int d, input bit down);
        if (down) return (d == 0) ? 0 : d - 1;
        return (d >= MAXC) ? MAXC : d + 1;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic convert(input int v, input bit poke);
        int e;
        int cycles;
        int bad;
        e = exp_result(v);
        @(negedge clk);
        level = v;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(!ready && !hold_n && dac == 0, "R2 armed", int'(ready), 0);
        cycles = 0;
        bad = 0;
        while (!ready && cycles < 500) begin
            if (int'(dac) != ((cycles > MAXC) ? MAXC : cycles)) bad++;
            if (hold_n) bad++;
            start = (poke && (cycles == 2 || cycles == 5));
            cycles++;
            @(negedge clk);
        end
        start = 1'b0;
        check(bad == 0, "R3 ramp", bad, 0);
        check(cycles == e + SYNC + 1, poke ? "R6 length" : "R5 length", cycles, e + SYNC + 1);
        check(int'(result) == e, poke ? "R6 result" : "R4 result", int'(result), e);
        check(hold_n == 1'b1, "R5 hold", int'(hold_n), 1);
        last_res = e;
        // R7: comparator changes while idle leave the result alone
        level = MAXC - v;
        repeat (4) @(negedge clk);
        check(int'(result) == e, "R7 stable", int'(result), e);
    endtask

    task automatic track_window(input int v, input int settle, input int win);
        int d1, d0;
        bit c3, c2, c1;
        int bad;
        @(negedge clk);
        level = v;
        repeat (settle) @(negedge clk);
        c3 = cmp; @(negedge clk);
        c2 = cmp; @(negedge clk);
        c1 = cmp; d1 = int'(dac); @(negedge clk);
        bad = 0;
        for (int k = 0; k < win; k++) begin
            d0 = int'(dac);
            if (d0 != step(d1, c3)) bad++;
            if (!ready || !hold_n || int'(result) != d0) bad++;
            c3 = c2; c2 = c1; c1 = cmp; d1 = d0;
            @(negedge clk);
        end
        check(bad == 0, "R8 tracking step", bad, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(ready && hold_n, "R1 ready", int'(ready), 1);
        check(dac == 0 && result == 0, "R1 code", int'(dac), 0);

        convert(0, 1'b0);
        convert(MAXC, 1'b0);
        convert(MAXC + 1, 1'b0);
        // R11: DAC left at full scale so the stale decision is high
        convert(7, 1'b0);
        convert(1, 1'b0);
        convert(23, 1'b1);
        convert(0, 1'b1);
        for (int i = 0; i < 25; i++) convert($urandom_range(MAXC + 1, 0), 1'b0);

        // R10: mode change in the middle of a conversion
        @(negedge clk);
        level = 50;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        mode = 1'b1;
        @(negedge clk);
        check(ready && hold_n, "R10 abort", int'(ready), 1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        check(ready == 1'b1, "R10 start ignored", int'(ready), 1);

        track_window(20, 2 * MAXC, 40);
        track_window(45, 10, 60);
        track_window(0, 2 * MAXC, 20);
        check(dac == 0, "R9 floor", int'(dac), 0);
        track_window(MAXC + 1, 3 * MAXC, 20);
        check(int'(dac) == MAXC, "R9 ceiling", int'(dac), MAXC);
        for (int i = 0; i < 4; i++) track_window($urandom_range(MAXC, 0), 2 * MAXC, 30);

        @(negedge clk);
        mode = 1'b0;
        @(negedge clk);
        check(ready && int'(result) == last_res, "R10 back to ramp", int'(result), last_res);
        convert(MAXC, 1'b0);
        convert(12, 1'b0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule